// File: doc/BRIEF.md
# Authority Table Entry Checker

This block decides whether an authorization index holds primary or secondary authority in an authority table kept in main storage. Each table byte packs four 2-bit entries. The high bit of each pair grants primary authority and the low bit grants secondary authority. A requester presents the index, the table origin, the table length, the kind of authority to test, the main-storage limit and the prefix value, then pulses `start`.

The block first runs a coarse length check. The length is compared at 16-entry granularity, and a failed check ends the request as not authorized without touching storage. Otherwise the block forms the entry byte address and wraps it to 31 bits. It checks that address against the storage limit and applies prefixing. It then reads the byte through a read port with a valid strobe and variable latency, and tests the selected bit.

A completed fetch also requests that the reference bit be set in the storage key of the absolute location it read. The block takes one request at a time. It reports exactly one of three outcomes: granted, denied or addressing fault.

Top module: `auth_entry_check`

## Requirements
- R1: When the index with its four low bits forced to zero is greater than the table length, the request ends as denied and no storage read is issued.
- R2: The entry byte address is the table origin plus the index shifted right by two, taken modulo 2^31 so that any carry beyond bit 30 is lost.
- R3: When the entry byte address is greater than the storage limit, the request ends as an addressing fault, with no read and no reference-bit request. An address equal to the limit is allowed.
- R4: The read address is the byte address after prefixing. An address in the 4 KB block at zero is moved to the block given by the prefix bits 30..12, an address in the prefix block is moved to block zero, and any other address is unchanged.
- R5: Index bits 1..0 equal to k select byte bits (7-2k) and (6-2k). The higher of the two is the primary bit and the lower is the secondary bit.
- R6: A fetched request is granted when the bit chosen by `sel_secondary` (0 = primary, 1 = secondary) is 1, and is denied otherwise.
- R7: Every completed read raises `ref_set` for one cycle, in the same cycle as `done`, with `ref_addr` equal to the absolute address that was read.
- R8: Each request yields `done` for exactly one cycle, together with exactly one of `granted`, `denied` or `addr_fault`.
- R9: `busy` is high from the cycle after `start` is taken until `done`. A `start` is ignored while busy. `mem_rd_req` and `mem_rd_addr` hold steady until `mem_rd_valid`, for any latency.
- R10: After reset all outputs are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken when idle |
| auth_idx | input | 16 | Authorization index |
| tbl_origin | input | 31 | Authority table origin (byte address) |
| tbl_len | input | 16 | Table length field |
| sel_secondary | input | 1 | 0 tests primary authority, 1 tests secondary |
| stor_limit | input | 31 | Highest valid main-storage byte address |
| prefix_base | input | 31 | Prefix value; bits 30..12 are used |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| granted | output | 1 | Outcome: authority held |
| denied | output | 1 | Outcome: authority not held |
| addr_fault | output | 1 | Outcome: addressing exception |
| mem_rd_req | output | 1 | Storage read request |
| mem_rd_addr | output | 31 | Absolute byte address to read |
| mem_rd_valid | input | 1 | Read data valid strobe |
| mem_rd_data | input | 8 | Read data byte |
| ref_set | output | 1 | Reference-bit update strobe |
| ref_addr | output | 31 | Absolute address for the reference-bit update |

## Verification
On every cycle the assertions check these properties:
- A failed length check or limit check ends the request with no read and the correct outcome.
- A pending read keeps its address steady.
- The reference strobe comes with `done`, carries the address just read, and never comes with a fault.
- `done` is a single-cycle pulse.

The arithmetic can only be shown by the bench's scenarios, which compare against an independent model: the 31-bit wrap of the byte address, the exact 16-entry length boundary, the limit boundary, the prefix swap in both directions, and bit selection across all four entry positions for both authority kinds, under several read latencies and with a `start` pulse arriving while busy.

// File: rtl/auth_chk_pkg.sv
package auth_chk_pkg;

    localparam int unsigned ENTRY_BITS       = 2;
    localparam int unsigned BYTE_BITS        = 8;
    localparam int unsigned ENTRIES_PER_BYTE = BYTE_BITS / ENTRY_BITS;
    localparam int unsigned SEL_BITS         = $clog2(ENTRIES_PER_BYTE);
    localparam int unsigned LEN_GRAN_BITS    = 4;

    localparam logic [BYTE_BITS-1:0] MASK_PRIMARY   = 8'h80;
    localparam logic [BYTE_BITS-1:0] MASK_SECONDARY = 8'h40;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH
    } auth_state_e;

    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_GRANT,
        OUT_DENY,
        OUT_FAULT
    } auth_outcome_e;

    // Move the selected pair to the top of the byte, then test one bit of it
    function automatic logic entry_bit_set(
        input logic [BYTE_BITS-1:0] tbl_byte,
        input logic [SEL_BITS-1:0]  sel,
        input logic                 secondary
    );
        logic [BYTE_BITS-1:0] aligned;
        aligned = tbl_byte << {sel, 1'b0};
        return |(aligned & (secondary ? MASK_SECONDARY : MASK_PRIMARY));
    endfunction

endpackage

// File: rtl/auth_addr_unit.sv
module auth_addr_unit
    import auth_chk_pkg::*;
#(
    parameter int unsigned ADDR_W = 31,
    parameter int unsigned IDX_W  = 16,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned BLK_W  = 12
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] origin,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] prefix,
    output logic              len_fail,
    output logic              limit_fail,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [ADDR_W-1:0] abs_addr
);
    localparam int unsigned CMP_W = (IDX_W > LEN_W) ? IDX_W : LEN_W;
    localparam int unsigned PG_W  = ADDR_W - BLK_W;

    logic [IDX_W-1:0]  idx_coarse;
    logic [CMP_W-1:0]  idx_cmp;
    logic [CMP_W-1:0]  len_cmp;
    logic [PG_W-1:0]   blk_num;
    logic [PG_W-1:0]   pfx_num;

    always_comb begin
        idx_coarse = {idx[IDX_W-1:LEN_GRAN_BITS], {LEN_GRAN_BITS{1'b0}}};
        idx_cmp    = CMP_W'(idx_coarse);
        len_cmp    = CMP_W'(len);
        len_fail   = idx_cmp > len_cmp;
    end

    // The sum is ADDR_W bits wide, so any carry out of the top bit is lost
    always_comb begin
        byte_addr  = origin + ADDR_W'(idx >> SEL_BITS);
        limit_fail = byte_addr > limit;
    end

    // Prefixing: exchange block zero with the prefix block
    always_comb begin
        blk_num = byte_addr[ADDR_W-1:BLK_W];
        pfx_num = prefix[ADDR_W-1:BLK_W];
        if (blk_num == '0)
            abs_addr = {pfx_num, byte_addr[BLK_W-1:0]};
        else if (blk_num == pfx_num)
            abs_addr = {{PG_W{1'b0}}, byte_addr[BLK_W-1:0]};
        else
            abs_addr = byte_addr;
    end

endmodule

// File: rtl/auth_entry_test.sv
module auth_entry_test
    import auth_chk_pkg::*;
(
    input  logic [BYTE_BITS-1:0] tbl_byte,
    input  logic [SEL_BITS-1:0]  sel,
    input  logic                 secondary,
    output logic                 pass
);
    always_comb pass = entry_bit_set(tbl_byte, sel, secondary);
endmodule

// File: rtl/auth_entry_check.sv
module auth_entry_check
    import auth_chk_pkg::*;
#(
    parameter int unsigned ADDR_W = 31,
    parameter int unsigned IDX_W  = 16,
    parameter int unsigned LEN_W  = 16,
    parameter int unsigned BLK_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  auth_idx,
    input  logic [ADDR_W-1:0] tbl_origin,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic              sel_secondary,
    input  logic [ADDR_W-1:0] stor_limit,
    input  logic [ADDR_W-1:0] prefix_base,
    output logic              busy,
    output logic              done,
    output logic              granted,
    output logic              denied,
    output logic              addr_fault,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [7:0]        mem_rd_data,
    output logic              ref_set,
    output logic [ADDR_W-1:0] ref_addr
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] origin;
        logic [LEN_W-1:0]  len;
        logic              secondary;
        logic [ADDR_W-1:0] limit;
        logic [ADDR_W-1:0] prefix;
    } auth_req_t;

    auth_state_e   state_q;
    auth_outcome_e outcome_q;
    auth_req_t     req_q;
    logic          ref_set_q;
    logic [ADDR_W-1:0] ref_addr_q;

    logic              len_fail;
    logic              limit_fail;
    logic [ADDR_W-1:0] byte_addr;
    logic [ADDR_W-1:0] abs_addr;
    logic              entry_pass;

    auth_addr_unit #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .BLK_W(BLK_W)
    ) u_addr (
        .idx        (req_q.idx),
        .origin     (req_q.origin),
        .len        (req_q.len),
        .limit      (req_q.limit),
        .prefix     (req_q.prefix),
        .len_fail   (len_fail),
        .limit_fail (limit_fail),
        .byte_addr  (byte_addr),
        .abs_addr   (abs_addr)
    );

    auth_entry_test u_test (
        .tbl_byte  (mem_rd_data),
        .sel       (req_q.idx[SEL_BITS-1:0]),
        .secondary (req_q.secondary),
        .pass      (entry_pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            outcome_q  <= OUT_NONE;
            req_q      <= '0;
            ref_set_q  <= 1'b0;
            ref_addr_q <= '0;
        end else begin
            outcome_q <= OUT_NONE;
            ref_set_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        req_q.idx       <= auth_idx;
                        req_q.origin    <= tbl_origin;
                        req_q.len       <= tbl_len;
                        req_q.secondary <= sel_secondary;
                        req_q.limit     <= stor_limit;
                        req_q.prefix    <= prefix_base;
                        state_q         <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (len_fail) begin
                        outcome_q <= OUT_DENY;
                        state_q   <= ST_IDLE;
                    end else if (limit_fail) begin
                        outcome_q <= OUT_FAULT;
                        state_q   <= ST_IDLE;
                    end else begin
                        state_q   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_rd_valid) begin
                        outcome_q  <= entry_pass ? OUT_GRANT : OUT_DENY;
                        ref_set_q  <= 1'b1;
                        ref_addr_q <= abs_addr;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy        = (state_q != ST_IDLE);
        granted     = (outcome_q == OUT_GRANT);
        denied      = (outcome_q == OUT_DENY);
        addr_fault  = (outcome_q == OUT_FAULT);
        done        = (outcome_q != OUT_NONE);
        mem_rd_req  = (state_q == ST_FETCH);
        mem_rd_addr = abs_addr;
        ref_set     = ref_set_q;
        ref_addr    = ref_addr_q;
    end

    AST_LEN_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && len_fail) |=> (denied && !mem_rd_req)); // R1

    AST_LIMIT_FAULT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !len_fail && limit_fail) |=> (addr_fault && !mem_rd_req && !ref_set)); // R3

    AST_REF_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ref_set |-> (done && !addr_fault)); // R7

    AST_REF_ADDR_READ: assert property (@(posedge clk) disable iff (rst)
        ref_set |-> (ref_addr == $past(mem_rd_addr))); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

endmodule

// File: tb/auth_entry_check_bench.sv
module auth_entry_check_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] auth_idx = '0;
    logic [30:0] tbl_origin = '0;
    logic [15:0] tbl_len = '0;
    logic        sel_secondary = 1'b0;
    logic [30:0] stor_limit = '0;
    logic [30:0] prefix_base = '0;
    logic        mem_rd_valid = 1'b0;
    logic [7:0]  mem_rd_data = '0;
    logic        busy, done, granted, denied, addr_fault, mem_rd_req, ref_set;
    logic [30:0] mem_rd_addr, ref_addr;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    auth_entry_check u_auth_entry_check (
        .clk(clk), .rst(rst), .start(start), .auth_idx(auth_idx),
        .tbl_origin(tbl_origin), .tbl_len(tbl_len), .sel_secondary(sel_secondary),
        .stor_limit(stor_limit), .prefix_base(prefix_base),
        .busy(busy), .done(done), .granted(granted), .denied(denied),
        .addr_fault(addr_fault), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .ref_set(ref_set), .ref_addr(ref_addr)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            mismatched++;
            $display("FAIL R9 watchdog expired: actual=%0d expected<=20000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // {busy, done, granted, denied, addr_fault, mem_rd_req, ref_set}
    function automatic logic [6:0] outs();
        return {busy, done, granted, denied, addr_fault, mem_rd_req, ref_set};
    endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Behavioural model of one request, compared against the ports every cycle
    task automatic run(input logic [15:0] idx, input logic [30:0] org, input logic [15:0] len,
                       input logic sec, input logic [30:0] lim, input logic [30:0] pfx,
                       input logic [7:0] data, input int lat, input bit poke, input string rq);
        logic [30:0] ba, ab;
        logic [7:0]  sh;
        logic        lf, af, ok;
        lf = ({idx[15:4], 4'h0} > len);
        ba = org + {15'd0, idx >> 2};
        af = !lf && (ba > lim);
        if (ba[30:12] == 19'd0)             ab = {pfx[30:12], ba[11:0]};
        else if (ba[30:12] == pfx[30:12])   ab = {19'd0, ba[11:0]};
        else                                ab = ba;
        sh = data << (2 * idx[1:0]);
        ok = sec ? sh[6] : sh[7];

        @(negedge clk);
        start = 1'b1; auth_idx = idx; tbl_origin = org; tbl_len = len;
        sel_secondary = sec; stor_limit = lim; prefix_base = pfx;
        @(negedge clk);
        start = 1'b0;
        chk(rq, "check-cycle outputs", {25'd0, outs()}, 32'b1000000);
        @(negedge clk);
        if (lf) begin
            chk(rq, "R1 length denial", {25'd0, outs()}, 32'b0101000);
        end else if (af) begin
            chk(rq, "R3 limit fault", {25'd0, outs()}, 32'b0100100);
        end else begin
            chk(rq, "fetch request", {25'd0, outs()}, 32'b1000010);
            chk(rq, "R4 read address", {1'b0, mem_rd_addr}, {1'b0, ab});
            for (int i = 0; i < lat; i++) begin
                if (poke && i == 0) begin
                    start = 1'b1; auth_idx = 16'hFFFF; tbl_origin = 31'h0123_4567; sel_secondary = ~sec;
                end
                @(negedge clk);
                start = 1'b0;
                chk("R9", "waiting outputs", {25'd0, outs()}, 32'b1000010);
                chk("R9", "held address", {1'b0, mem_rd_addr}, {1'b0, ab});
            end
            mem_rd_valid = 1'b1; mem_rd_data = data;
            @(negedge clk);
            mem_rd_valid = 1'b0; mem_rd_data = 8'h00;
            chk(rq, "R6 outcome", {25'd0, outs()}, {25'd0, 1'b0, 1'b1, ok, ~ok, 1'b0, 1'b0, 1'b1});
            chk("R7", "reference address", {1'b0, ref_addr}, {1'b0, ab});
        end
        @(negedge clk);
        chk("R8", "quiet after done", {25'd0, outs()}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "reset outputs", {25'd0, outs()}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "idle after reset", {25'd0, outs()}, 32'd0);

        // R1: coarse length check, failing and at the exact boundary
        run(16'h0040, 31'h0000_8000, 16'h003F, 1'b0, 31'h00FF_FFFF, 31'h0003_5000, 8'hFF, 1, 0, "R1");
        run(16'h004F, 31'h0000_8000, 16'h0040, 1'b0, 31'h00FF_FFFF, 31'h0003_5000, 8'hC0, 2, 0, "R1");
        // R2: carry beyond bit 30 discarded; lands in block zero, so prefixed (R4)
        run(16'h0008, 31'h7FFF_FFFF, 16'hFFFF, 1'b0, 31'h00FF_FFFF, 31'h0003_5000, 8'h80, 0, 0, "R2");
        // R3: above the limit faults, equal to the limit is allowed
        run(16'h0100, 31'h0001_0000, 16'hFFFF, 1'b0, 31'h0001_003F, 31'h0003_5000, 8'hFF, 1, 0, "R3");
        run(16'h0100, 31'h0001_0000, 16'hFFFF, 1'b0, 31'h0001_0040, 31'h0003_5000, 8'h80, 1, 0, "R3");
        // R4: prefix block maps to block zero; other blocks unchanged
        run(16'h0010, 31'h0003_5100, 16'hFFFF, 1'b1, 31'h00FF_FFFF, 31'h0003_5000, 8'h40, 3, 0, "R4");
        run(16'h0010, 31'h0004_7100, 16'hFFFF, 1'b1, 31'h00FF_FFFF, 31'h0003_5000, 8'h40, 1, 0, "R4");
        // R5 and R6: byte 10_01_11_00 over all four positions, both authority kinds
        for (int k = 0; k < 4; k++) begin
            run(16'h0020 + 16'(k), 31'h0002_2000, 16'h0030, 1'b0, 31'h00FF_FFFF, 31'h0003_5000, 8'b1001_1100, k, 0, "R5");
            run(16'h0020 + 16'(k), 31'h0002_2000, 16'h0030, 1'b1, 31'h00FF_FFFF, 31'h0003_5000, 8'b1001_1100, 4 - k, 0, "R6");
        end
        // R9: a start pulse while busy is ignored, with long latency
        run(16'h0031, 31'h0002_2000, 16'h0030, 1'b1, 31'h00FF_FFFF, 31'h0003_5000, 8'b0001_0000, 6, 1, "R9");
        @(negedge clk);
        chk("R9", "no extra request after ignored start", {25'd0, outs()}, 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule